// File: doc/BRIEF.md
# Five-Output Clock Enable Controller with Write-Only I2C Slave

This block receives enable settings for five gated copies of one reference clock over a two-wire serial bus. A fast system clock samples the bus clock and data lines. Framing logic finds start and stop conditions. It then checks the first byte against a fixed 7-bit device address with the write bit clear. On a match it acknowledges each byte by pulling the data line low through an open-drain enable.

The two bytes after the address are a header. Both are acknowledged, and their contents are thrown away. After the header come the data bytes, taken by position: the first loads control byte 0, the second loads control byte 1, and any further bytes are acknowledged and dropped. No register can be selected directly, so changing output 4 means also sending control byte 0. Nothing can be read back. Each enable bit gates its own copy of the reference clock, and a disabled copy sits low.

Each enable is re-timed on the falling edge of the reference clock, so it only takes effect during the low phase. This means a clock copy never produces a shortened pulse when it is switched on or off.

Top module: `clkbuf_ctl_top`

## Requirements
- R1: After reset all five enables are 1, so every `clk_out` bit follows `ref_clk`.
- R2: An address byte of 0xD2 (address 1101001, write bit 0, MSB first) is acknowledged. The block holds the data line low through `sda_oe` = 1 for the whole ninth SCL high phase, and asserts `sda_oe` only while SCL is low.
- R3: An address byte with the read bit set (0xD3), or with any other address, gets no acknowledge. The block then ignores the bus until the next start, and no output changes.
- R4: The two header bytes after the address are acknowledged whatever their values, and have no effect on the outputs.
- R5: The first data byte sets output 0 from bit 0, output 1 from bit 1, output 2 from bit 6 and output 3 from bit 7. Bits 2 to 5 have no effect.
- R6: Bit 0 of the second data byte sets output 4. Bits 7 to 1 have no effect.
- R7: Enable bit 1 makes the output follow `ref_clk`. Enable bit 0 holds the output low.
- R8: An enable changes only after its whole byte has been acknowledged. A transfer stopped part-way through a byte changes nothing. A transfer that ends after one data byte leaves output 4 as it was.
- R9: Data bytes after the second one are acknowledged and discarded.
- R10: A start condition at any point restarts the framing at the address byte. A stop condition releases the data line and returns the block to idle.
- R11: An output only changes at the same moment as an edge of `ref_clk`, so no output pulse is ever shortened by an enable change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial bus clock line |
| sda_in | input | 1 | Serial bus data line, as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| ref_clk | input | 1 | Reference clock to be gated |
| clk_out | output | 5 | Gated clock copies; bit n is output n |

## Verification
The assertions assume the bus follows the framing rules. SDA changes while SCL is high only to form a start or a stop. Each SCL phase lasts many system clocks, so the synchronized lines keep the order of events, and the acknowledge is driven and released well inside the SCL low phase. The bench master keeps a quarter-bit spacing of 20 system clocks between any data change and the next SCL edge, and changes SDA only at least one quarter after SCL falls. A monitor sampling between reference edges checks that outputs move only together with `ref_clk`.

// File: rtl/clkbuf_pkg.sv
package clkbuf_pkg;
  localparam int NUM_OUT = 5;
  localparam int IDX_W   = 3;
  // byte positions inside one addressed transfer
  localparam logic [IDX_W-1:0] IDX_ADDR = 3'd0;
  localparam logic [IDX_W-1:0] IDX_B0   = 3'd3;
  localparam logic [IDX_W-1:0] IDX_B1   = 3'd4;
  localparam logic [IDX_W-1:0] IDX_LAST = 3'd5;
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK, ST_SKIP} frame_st_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave
  import clkbuf_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h69
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  output logic               sda_oe,
  output logic [NUM_OUT-1:0] en_q
);
  localparam logic [7:0] ADDR_WR = {ADDR7, 1'b0};

  frame_st_t        state;
  logic [7:0]       shreg;
  logic [2:0]       bitcnt;
  logic             full;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      shreg  <= '0;
      bitcnt <= '0;
      full   <= 1'b0;
      idx    <= IDX_ADDR;
      sda_oe <= 1'b0;
      en_q   <= '1;
    end else if (start_det) begin
      state  <= ST_RX;
      bitcnt <= '0;
      full   <= 1'b0;
      idx    <= IDX_ADDR;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) full <= 1'b1;
          end else if (scl_fall && full) begin
            full <= 1'b0;
            if (idx == IDX_ADDR && shreg != ADDR_WR) begin
              state <= ST_SKIP;
            end else begin
              state  <= ST_ACK;
              sda_oe <= 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_RX;
            bitcnt <= '0;
            if (idx == IDX_B0) begin
              en_q[0] <= shreg[0];
              en_q[1] <= shreg[1];
              en_q[2] <= shreg[6];
              en_q[3] <= shreg[7];
            end
            if (idx == IDX_B1) en_q[4] <= shreg[0];
            if (idx != IDX_LAST) idx <= idx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  a_r2_ack_only_own_write: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK && idx == IDX_ADDR) |-> shreg == ADDR_WR);
  a_r2_ack_in_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);
  a_r3_skip_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !sda_oe);
  a_r8_update_on_commit: assert property (@(posedge clk) disable iff (rst)
    !$stable(en_q) |-> $past(state == ST_ACK && scl_fall));
  a_r10_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_oe && state == ST_IDLE));
endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate #(
  parameter int NUM_OUT = 5,
  parameter int STAGES  = 2
) (
  input  logic               rst,
  input  logic               ref_clk,
  input  logic [NUM_OUT-1:0] en_in,
  output logic [NUM_OUT-1:0] clk_out
);
  logic [NUM_OUT-1:0] en_pipe [STAGES];

  // enables move only on the falling reference edge
  always_ff @(negedge ref_clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) en_pipe[s] <= '1;
    end else begin
      en_pipe[0] <= en_in;
      for (int s = 1; s < STAGES; s++) en_pipe[s] <= en_pipe[s-1];
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
    assign clk_out[g] = ref_clk & en_pipe[STAGES-1][g];
  end
endmodule

// File: rtl/clkbuf_ctl_top.sv
module clkbuf_ctl_top
  import clkbuf_pkg::*;
#(
  parameter logic [6:0] ADDR7       = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic               ref_clk,
  output logic [NUM_OUT-1:0] clk_out
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [NUM_OUT-1:0] en_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_wr_slave #(.ADDR7(ADDR7)) u_slave (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .en_q(en_q)
  );

  clk_out_gate #(.NUM_OUT(NUM_OUT), .STAGES(SYNC_STAGES)) u_gate (
    .rst(rst), .ref_clk(ref_clk), .en_in(en_q), .clk_out(clk_out)
  );
endmodule

// File: tb/clkbuf_ctl_top_test.sv
`timescale 1ns/100ps
module clkbuf_ctl_top_test;
  localparam real Q = 400.0;
  logic clk = 1'b0, rst = 1'b1, ref_clk = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [4:0] clk_out;
  wire sda_bus = sda_m & ~sda_oe;
  int checks = 0, errors = 0, runts = 0;
  bit done = 1'b0, mon_on = 1'b0;
  logic [4:0] model = 5'h1F;

  always #10 clk = ~clk;
  always #15 ref_clk = ~ref_clk;

  clkbuf_ctl_top uut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus),
    .sda_oe(sda_oe), .ref_clk(ref_clk), .clk_out(clk_out)
  );

  // entries: {data byte count, byte0, byte1, byte2}
  localparam logic [31:0] VEC [10] = '{
    32'h02_00_00_00, 32'h02_FF_FF_00, 32'h02_01_00_00, 32'h02_02_00_00,
    32'h02_40_00_00, 32'h02_80_00_00, 32'h02_00_01_00, 32'h02_3C_FE_00,
    32'h01_C3_00_00, 32'h03_00_01_FF};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_out(input logic [4:0] exp, input string req);
    repeat (8) @(posedge ref_clk);
    #3 chk(clk_out == exp, req, clk_out, exp);
    @(negedge ref_clk);
    #3 chk(clk_out == 5'h00, req, clk_out, 0);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int k = 7; k > 7 - n; k--) begin
      sda_m = b[k]; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
    end
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; #Q; scl = 1'b1; #Q;
    ack = (sda_bus == 1'b0);
    #Q; scl = 1'b0; #Q;
  endtask

  task automatic xfer(input logic [7:0] a, input int nb, input logic [7:0] b0,
                      input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] hdr);
    bit ack;
    bit exp_ack = (a == 8'hD2);
    logic [7:0] data [3] = '{b0, b1, b2};
    i2c_start();
    write_byte(a, ack);
    chk(ack == exp_ack, exp_ack ? "R2 address ack" : "R3 no ack", ack, exp_ack);
    write_byte(hdr, ack);
    chk(ack == exp_ack, "R4 command byte ack", ack, exp_ack);
    write_byte(~hdr, ack);
    chk(ack == exp_ack, "R4 count byte ack", ack, exp_ack);
    for (int i = 0; i < nb; i++) begin
      write_byte(data[i], ack);
      chk(ack == exp_ack, i == 2 ? "R9 extra byte ack" : "R5 R6 data ack", ack, exp_ack);
    end
    i2c_stop();
  endtask

  function automatic logic [4:0] apply(input logic [4:0] m, input int nb,
                                       input logic [7:0] b0, input logic [7:0] b1);
    logic [4:0] r = m;
    if (nb >= 1) r[3:0] = {b0[7], b0[6], b0[1], b0[0]};
    if (nb >= 2) r[4] = b1[0];
    return r;
  endfunction

  // R11: an output may move only together with ref_clk
  initial begin
    logic prev_ref;
    logic [4:0] prev_out;
    wait (mon_on);
    #0.5;
    prev_ref = ref_clk; prev_out = clk_out;
    forever begin
      #1;
      for (int i = 0; i < 5; i++)
        if (clk_out[i] != prev_out[i] && ref_clk == prev_ref) runts++;
      prev_ref = ref_clk; prev_out = clk_out;
    end
  end

  initial begin
    #5ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    repeat (5) @(posedge clk);
    rst = 1'b0;
    mon_on = 1'b1;
    #1 chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    check_out(5'h1F, "R1 reset all enabled");

    for (int v = 0; v < 10; v++) begin
      int nb = int'(VEC[v][31:24]);
      xfer(8'hD2, nb, VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 8'(v * 37));
      model = apply(model, nb, VEC[v][23:16], VEC[v][15:8]);
      check_out(model, v == 8 ? "R8 single byte keeps out4" :
                       v == 9 ? "R9 extra byte discarded" : "R5 R6 R7 mapping");
    end

    // R3: read direction and a foreign address are both ignored
    xfer(8'hD3, 2, 8'hFF, 8'hFE, 8'h00, 8'h11);
    check_out(model, "R3 read request ignored");
    xfer(8'hA2, 2, 8'hFF, 8'hFE, 8'h00, 8'h22);
    check_out(model, "R3 other address ignored");

    // R8: stop in the middle of control byte 0
    i2c_start();
    write_byte(8'hD2, ack); write_byte(8'h00, ack); write_byte(8'h00, ack);
    send_bits(8'hFF, 5);
    sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
    check_out(model, "R8 partial byte ignored");

    // R10: repeated start restarts at the address byte
    i2c_start();
    write_byte(8'hD2, ack); write_byte(8'h00, ack);
    i2c_start();
    write_byte(8'hD2, ack);
    chk(ack, "R10 address after repeated start", ack, 1);
    write_byte(8'h55, ack); write_byte(8'hAA, ack);
    write_byte(8'h41, ack); write_byte(8'h01, ack);
    i2c_stop();
    #200 chk(sda_oe == 1'b0, "R10 stop releases line", sda_oe, 0);
    model = apply(model, 2, 8'h41, 8'h01);
    check_out(model, "R10 data after repeated start");

    chk(runts == 0, "R11 no shortened pulse", runts, 0);

    rst = 1'b1;
    repeat (5) @(posedge clk);
    rst = 1'b0;
    check_out(5'h1F, "R1 second reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule